// File: doc/BRIEF.md
# Serial Audio Receiver with Framing Auto-Detect

This block takes stereo audio arriving over a three-wire serial link: a bit clock, a frame clock and a data line. It runs entirely on the bit clock. Each rising edge samples the frame clock and one data bit, MSB first. The block turns the stream into a parallel pair of 16-bit left and right samples. A one-cycle strobe marks each complete pair.

Two framings are handled without any configuration. In right-justified framing the frame clock is high for the left channel and low for the right channel. Each word is the last 16 bits that arrive before a frame-clock edge. In time-multiplexed framing a short frame-clock pulse marks the start of a frame, and the left word and the right word follow it back to back. The receiver measures every high pulse of the frame clock and picks the framing from its width. A static input sets where the first data bit sits relative to the sync pulse.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held, and on the first cycle after it, `pair_vld` is 0, `left_o` and `right_o` are 0 and `dsp_mode` is 0 (right-justified).
- R2: In right-justified framing, the left word is the 16 bits sampled on the 16 edges before the first edge that samples the frame clock low, MSB first. The right word is the 16 bits sampled before the first edge that samples it high again. The pair appears with `pair_vld` = 1 in the cycle that follows that rising-frame edge.
- R3: Right-justified phases of any length of 16 bit clocks or more are accepted, and the high and low phases need not be equal. Bits sampled before the final 16 of a phase have no effect on the word.
- R4: A frame-clock high pulse sampled on 1 to 4 consecutive edges selects time-multiplexed framing. `dsp_mode` reads 1 from the cycle after the first edge that samples the frame clock low again.
- R5: A high pulse sampled on 5 or more edges selects right-justified framing. `dsp_mode` reads 0 from the cycle after the edge that ends the pulse.
- R6: In time-multiplexed framing with `sync_lag` = 0, let edge s be the first edge that samples the pulse high. The left MSB is sampled on edge s. Left bits are on edges s to s+15 and right bits on edges s+16 to s+31. `pair_vld` = 1 in the cycle after edge s+32. The next pulse may start as early as edge s+32.
- R7: With `sync_lag` = 1 every bit position moves one edge later. The left MSB is on edge s+1, and `pair_vld` = 1 in the cycle after edge s+33.
- R8: `pair_vld` is high for exactly one cycle per decoded frame and low at every other time. `left_o` and `right_o` change only together with the strobe.
- R9: After reset, a frame whose frame-clock rise was not seen is discarded. Its pair is never strobed.
- R10: When the detected framing changes from time-multiplexed to right-justified, the first right-justified frame is discarded. A time-multiplexed frame that follows right-justified frames is decoded in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frm | input | 1 | Frame clock: channel select, or a short sync pulse |
| sdat | input | 1 | Serial data, MSB first |
| sync_lag | input | 1 | Time-multiplexed alignment: 0 puts the left MSB on the first high edge, 1 puts it one edge later |
| left_o | output | 16 | Last decoded left sample |
| right_o | output | 16 | Last decoded right sample |
| pair_vld | output | 1 | One-cycle strobe for a new sample pair |
| dsp_mode | output | 1 | 1 when time-multiplexed framing is detected |

## Verification
The properties assume well-formed serial input. Every frame lasts at least 32 bit clocks, right-justified phases last at least 16, sync pulses last at most 4, and `sync_lag` is constant between resets. Under those limits two strobes cannot fall on neighbouring cycles, and framing changes can occur only on a falling frame-clock edge. The stimulus is built only from whole-frame tasks that respect these widths. `sync_lag` changes only while reset is held. The one deliberately partial frame is placed directly after reset, where R9 expects it.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int WORD_W       = 16;
    localparam int SYNC_MAX_DEF = 4;

    typedef enum logic {
        FRM_RJ  = 1'b0,
        FRM_DSP = 1'b1
    } frame_e;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t left;
        word_t right;
    } pair_t;

    // A high run of `width` sampled edges counts as a sync pulse.
    function automatic logic short_pulse(input int width, input int limit);
        return (width > 0) && (width <= limit);
    endfunction

endpackage

// File: rtl/sarx_frame_watch.sv
module sarx_frame_watch
    import sarx_pkg::*;
#(
    parameter int SYNC_MAX = SYNC_MAX_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   frm,
    output logic   rise,
    output logic   fall,
    output logic   started,
    output frame_e mode,
    output logic   flip
);

    localparam int HI_W = $clog2(SYNC_MAX + 2);
    localparam logic [HI_W-1:0] HI_TOP = '1;

    logic            frm_q;
    logic            hist_ok;
    logic [HI_W-1:0] hi_cnt;
    frame_e          mode_nx;

    assign rise = hist_ok & frm & ~frm_q;
    assign fall = hist_ok & ~frm & frm_q;

    // Pulse-width decision at the falling edge of the frame clock.
    always_comb begin
        mode_nx = mode;
        if (fall) begin
            mode_nx = short_pulse(int'(hi_cnt), SYNC_MAX) ? FRM_DSP : FRM_RJ;
        end
    end

    assign flip = (mode_nx != mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_q   <= 1'b0;
            hist_ok <= 1'b0;
            started <= 1'b0;
            hi_cnt  <= HI_TOP;
            mode    <= FRM_RJ;
        end else begin
            frm_q   <= frm;
            hist_ok <= 1'b1;
            mode    <= mode_nx;
            if (rise) begin
                started <= 1'b1;
                hi_cnt  <= HI_W'(1);
            end else if (frm && hi_cnt != HI_TOP) begin
                hi_cnt  <= hi_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sarx_slot_count.sv
module sarx_slot_count
    import sarx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic lag,
    output logic left_tick,
    output logic right_tick
);

    localparam int SLOT_W = $clog2(2 * W + 2) + 1;
    localparam logic [SLOT_W-1:0] SLOT_TOP = '1;

    logic [SLOT_W-1:0] pos;
    logic [SLOT_W-1:0] left_at;
    logic [SLOT_W-1:0] right_at;

    assign left_at  = SLOT_W'(W)     + SLOT_W'(lag);
    assign right_at = SLOT_W'(2 * W) + SLOT_W'(lag);

    // The value of pos on an edge is the number of edges since the sync edge.
    assign left_tick  = (pos == left_at);
    assign right_tick = (pos == right_at);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= SLOT_TOP;
        end else if (rise) begin
            pos <= SLOT_W'(1);
        end else if (pos != SLOT_TOP) begin
            pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/sarx_shift.sv
module sarx_shift
    import sarx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sdat,
    output logic [W-1:0] hist
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else begin
            hist <= {hist[W-2:0], sdat};
        end
    end

endmodule

// File: rtl/sarx_pair_assemble.sv
module sarx_pair_assemble
    import sarx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  frame_e mode,
    input  logic   rise,
    input  logic   fall,
    input  logic   started,
    input  logic   flip,
    input  logic   left_tick,
    input  logic   right_tick,
    input  word_t  hist,
    output pair_t  pair,
    output logic   vld
);

    logic  left_cap;
    logic  right_cap;
    logic  armed;
    word_t held;

    always_comb begin
        if (mode == FRM_RJ) begin
            left_cap  = fall & started;
            right_cap = rise;
        end else begin
            left_cap  = left_tick;
            right_cap = right_tick;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            armed <= 1'b0;
            vld   <= 1'b0;
            pair  <= '0;
        end else begin
            vld <= 1'b0;
            if (left_cap) begin
                held  <= hist;
                armed <= 1'b1;
            end
            if (right_cap) begin
                armed <= 1'b0;
                if (armed) begin
                    pair <= '{left: held, right: hist};
                    vld  <= 1'b1;
                end
            end
            // A framing change invalidates any half-built pair.
            if (flip) begin
                armed <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SYNC_MAX = SYNC_MAX_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm,
    input  logic              sdat,
    input  logic              sync_lag,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              pair_vld,
    output logic              dsp_mode
);

    logic   rise;
    logic   fall;
    logic   started;
    logic   flip;
    frame_e mode;
    logic   left_tick;
    logic   right_tick;
    word_t  hist;
    pair_t  pair;

    sarx_frame_watch #(.SYNC_MAX(SYNC_MAX)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .frm     (frm),
        .rise    (rise),
        .fall    (fall),
        .started (started),
        .mode    (mode),
        .flip    (flip)
    );

    sarx_slot_count #(.W(WORD_W)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .rise       (rise),
        .lag        (sync_lag),
        .left_tick  (left_tick),
        .right_tick (right_tick)
    );

    sarx_shift #(.W(WORD_W)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .sdat (sdat),
        .hist (hist)
    );

    sarx_pair_assemble u_pair (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .rise       (rise),
        .fall       (fall),
        .started    (started),
        .flip       (flip),
        .left_tick  (left_tick),
        .right_tick (right_tick),
        .hist       (hist),
        .pair       (pair),
        .vld        (pair_vld)
    );

    assign left_o   = pair.left;
    assign right_o  = pair.right;
    assign dsp_mode = (mode == FRM_DSP);

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker
    import sarx_pkg::*;
#(
    parameter int SYNC_MAX = SYNC_MAX_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic              frm,
    input logic              pair_vld,
    input logic              dsp_mode,
    input logic [WORD_W-1:0] left_o,
    input logic [WORD_W-1:0] right_o
);

    logic [7:0] run;
    logic [7:0] last_hi;

    // Independent measure of the most recent completed frame-clock high run.
    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= '0;
            last_hi <= '0;
        end else begin
            if (frm) begin
                if (run != 8'hFF) run <= run + 8'd1;
            end else begin
                run <= '0;
                if (run != 8'd0) last_hi <= run;
            end
        end
    end

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (rst)
        pair_vld |=> !pair_vld);

    a_r8_outputs_change_with_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable({left_o, right_o}) |-> pair_vld);

    a_r2_rj_pair_at_rise: assert property (@(posedge clk) disable iff (rst)
        (pair_vld && !dsp_mode) |-> ($past(frm) && !$past(frm, 2)));

    a_r4_mode_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(dsp_mode) |-> ($past(frm, 2) && !$past(frm)));

    a_r4_short_pulse_enters_dsp: assert property (@(posedge clk) disable iff (rst)
        $rose(dsp_mode) |-> (last_hi != 8'd0 && int'(last_hi) <= SYNC_MAX));

    a_r5_long_pulse_leaves_dsp: assert property (@(posedge clk) disable iff (rst)
        $fell(dsp_mode) |-> (int'(last_hi) > SYNC_MAX));

endmodule

bind serial_audio_rx sarx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .frm      (frm),
    .pair_vld (pair_vld),
    .dsp_mode (dsp_mode),
    .left_o   (left_o),
    .right_o  (right_o)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm = 1'b0;
    logic        sdat = 1'b0;
    logic        sync_lag = 1'b0;
    logic [15:0] left_o;
    logic [15:0] right_o;
    logic        pair_vld;
    logic        dsp_mode;

    serial_audio_rx uut (
        .clk      (clk),
        .rst      (rst),
        .frm      (frm),
        .sdat     (sdat),
        .sync_lag (sync_lag),
        .left_o   (left_o),
        .right_o  (right_o),
        .pair_vld (pair_vld),
        .dsp_mode (dsp_mode)
    );

    always #2 clk = ~clk;

    int edge_no = 0;
    always @(posedge clk) edge_no++;

    int    vectors = 0;
    int    miscompares = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string req = "R1";

    typedef struct {
        int          e;
        logic [15:0] l;
        logic [15:0] r;
    } exp_t;
    exp_t q[$];

    logic exp_mode = 1'b0;
    int   pend_e = -1;
    logic pend_v = 1'b0;
    bit   bmode = 1'b0;
    bit   seen = 1'b0;
    int   last_edge = 0;

    // Drive one bit; it is sampled on edge last_edge.
    task automatic put(input logic l, input logic d);
        @(negedge clk);
        frm = l;
        sdat = d;
        last_edge = edge_no + 1;
    endtask

    task automatic rj_frame(input logic [15:0] lw, input logic [15:0] rw,
                            input int hi, input int lo, input string tag);
        bit ok;
        ok = 1'b0;
        req = tag;
        seen = 1'b1;
        for (int i = 0; i < hi; i++) begin
            int k;
            k = i - (hi - 16);
            put(1'b1, (k >= 0) ? lw[15-k] : 1'($urandom));
        end
        for (int j = 0; j < lo; j++) begin
            int k;
            k = j - (lo - 16);
            put(1'b0, (k >= 0) ? rw[15-k] : 1'($urandom));
            if (j == 0) begin
                ok = (bmode == 1'b0) && seen;
                bmode = 1'b0;
                pend_e = last_edge;
                pend_v = 1'b0;
            end
        end
        // Pair completes on the next edge, which samples the frame clock high.
        if (ok) q.push_back('{last_edge + 1, lw, rw});
    endtask

    task automatic dsp_frame(input logic [15:0] lw, input logic [15:0] rw,
                             input int hi, input int len, input string tag);
        int off;
        off = int'(sync_lag);
        req = tag;
        seen = 1'b1;
        for (int i = 0; i < len; i++) begin
            int   k;
            logic d;
            k = i - off;
            if (k >= 0 && k < 16)       d = lw[15-k];
            else if (k >= 16 && k < 32) d = rw[31-k];
            else                        d = 1'($urandom);
            put(i < hi, d);
            if (i == 0 && hi <= 4) q.push_back('{last_edge + 32 + off, lw, rw});
            if (i == hi) begin
                bmode = (hi <= 4);
                pend_e = last_edge;
                pend_v = bmode;
            end
        end
    endtask

    task automatic fail_line(input string r, input string what,
                             input logic [32:0] act, input logic [32:0] exp);
        miscompares++;
        $display("FAIL %s %s: actual %h expected %h (edge %0d)", r, what, act, exp, edge_no);
    endtask

    always @(negedge clk) begin : cycle_cmp
        logic ev;
        if (chk_on) begin
            if (pend_e >= 0 && edge_no >= pend_e) begin
                exp_mode = pend_v;
                pend_e = -1;
            end
            while (q.size() > 0 && q[0].e < edge_no) void'(q.pop_front());
            ev = (q.size() > 0) && (q[0].e == edge_no);
            vectors++;
            if (pair_vld !== ev)
                fail_line(ev ? req : "R8", "pair_vld", {32'd0, pair_vld}, {32'd0, ev});
            else if (ev && ({left_o, right_o} !== {q[0].l, q[0].r}))
                fail_line(req, "pair", {1'b0, left_o, right_o}, {1'b0, q[0].l, q[0].r});
            if (dsp_mode !== exp_mode)
                fail_line(req, "dsp_mode", {32'd0, dsp_mode}, {32'd0, exp_mode});
            if (ev) void'(q.pop_front());
        end
    end

    // R1: reset state, checked while reset is held.
    task automatic do_reset(input logic hold_frm, input logic lag);
        @(negedge clk);
        chk_on = 1'b0;
        rst = 1'b1;
        frm = hold_frm;
        sdat = 1'b0;
        sync_lag = lag;
        q.delete();
        exp_mode = 1'b0;
        pend_e = -1;
        bmode = 1'b0;
        seen = 1'b0;
        repeat (3) @(negedge clk);
        vectors++;
        if ({pair_vld, dsp_mode, left_o, right_o} !== 34'd0)
            fail_line("R1", "reset outputs", {1'b0, left_o, right_o},
                      {33'd0});
        rst = 1'b0;
        chk_on = 1'b1;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #600000;
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        // Mode B alignment (sync_lag = 0), frame clock high through reset.
        do_reset(1'b1, 1'b0);
        req = "R9";                                   // R9: partial first frame
        repeat (10) put(1'b1, 1'($urandom));
        repeat (16) put(1'b0, 1'($urandom));
        rj_frame(16'h8001, 16'h7FFE, 16, 16, "R2");
        rj_frame(16'hA53C, 16'h3CA5, 20, 24, "R3");   // R3: asymmetric phases
        rj_frame(16'hFFFF, 16'h0000, 40, 16, "R3");
        dsp_frame(16'h1234, 16'hFEDC, 1, 40, "R10");  // R10: entry from RJ decoded
        dsp_frame(16'h0F0F, 16'hF0F0, 4, 32, "R4");   // R4: 4-wide pulse, back to back
        dsp_frame(16'h5555, 16'hAAAA, 2, 40, "R6");   // R6: lag 0 alignment
        dsp_frame(16'h1111, 16'h2222, 5, 40, "R5");   // R5: 5-wide pulse leaves DSP
        rj_frame(16'h4321, 16'h8765, 16, 16, "R5");
        dsp_frame(16'h0001, 16'h8000, 3, 40, "R4");
        rj_frame(16'hDEAD, 16'hBEEF, 16, 16, "R10");  // R10: discarded after DSP
        rj_frame(16'h6C6C, 16'h9393, 18, 17, "R10");
        req = "R2";
        repeat (20) put(1'b1, 1'b0);

        // Mode A alignment (sync_lag = 1), idle low after reset.
        do_reset(1'b0, 1'b1);
        repeat (3) put(1'b0, 1'b0);
        dsp_frame(16'hC3C3, 16'h3C3C, 1, 40, "R7");   // R7: lag 1 alignment
        dsp_frame(16'h8000, 16'h0001, 3, 33, "R7");
        dsp_frame(16'hBEEF, 16'hCAFE, 4, 40, "R7");
        rj_frame(16'h1357, 16'h2468, 16, 16, "R10");
        rj_frame(16'hF00D, 16'h0FF0, 16, 16, "R2");
        req = "R8";                                   // R8: no stray strobes
        repeat (20) put(1'b1, 1'b0);
        repeat (4) @(negedge clk);
        if (q.size() != 0) fail_line("R8", "pending pairs", 33'(q.size()), 33'd0);
        chk_on = 1'b0;
        summary();
    end

endmodule